// File: doc/BRIEF.md
# Half-duplex SPI flash master

This block is a register-mapped serial master for serial flash devices. Software places up to four command bytes in a command word and up to thirty-two data bytes in a shared buffer of eight words. It then sets three separate bit counts, one each for the command, transmit-data and receive-data phases, and writes a start bit. One transaction follows. The command bits go out first, then the transmit bytes, then the incoming bits are captured back into the same data buffer. Software polls a busy flag and reads the received bytes out of the buffer.

The serial clock is the system clock divided by a programmable divisor of 2 to 4097. Bit order inside each byte can be set to LSB-first. The select lines are written directly by software, one enable bit per device, so that one select can stay low across several transactions. Only clock mode 0 is built: the clock idles low, output data changes on the falling edge and input data is sampled on the rising edge. The polarity and phase bits can be stored and read back, but they have no effect.

Top module: `spim_flash_master`

## Requirements
- R1: After reset the busy flag (control register 0x00, bit 16) reads 0, the serial clock is low, both select outputs are high, and the command (0x04), data (0x08 to 0x24), configuration (0x28) and count (0x2C) registers read 0.
- R2: Writing a 1 to bit 8 of the control register at 0x00 while idle starts a transaction. Bit 16 reads 1 for exactly (command + transmit + receive bit counts) × divisor clock cycles and then reads 0.
- R3: The divisor is configuration bits 27:16 plus 2, which covers 2 to 4097. Each bit takes one full divisor period. The number of rising serial-clock edges equals the total bit count.
- R4: The count register at 0x2C holds the command bit count in bits 29:24 (0 to 32), the receive bit count in bits 20:12 (0 to 256) and the transmit bit count in bits 8:0 (0 to 256). The phases always run in the order command, transmit, receive.
- R5: The command word goes out most-significant byte first: bits 31:24, then 23:16, then 15:8, then 7:0.
- R6: Transmit byte k is taken from data word 0x08 + 4·(k/4), bits 8·(k mod 4)+7 down to 8·(k mod 4). Bits are MSB-first within each byte when configuration bit 3 is 0.
- R7: When configuration bit 3 is 1, every byte of both the command and the data phases is sent and received LSB-first.
- R8: Receive bit j is sampled on a rising serial-clock edge and stored into byte j/8 of the data buffer, using the R6 layout and the R6/R7 bit order. Bytes beyond the received count keep their contents.
- R9: The serial clock is low whenever the block is not busy. The output data bit does not change while the serial clock is high.
- R10: Bit n of the select register at 0x38 drives select output n low. Writing 0 drives it high. The register can be written at any time.
- R11: A start request made while busy is ignored. The transaction in progress keeps its length and its bit stream.
- R12: A start with all three counts zero sets busy for exactly one cycle and produces no serial-clock edge.
- R13: Writes to the command, data, configuration and count registers made while busy are discarded. They change neither the transaction in progress nor the stored register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low device selects |

## Verification
Directed transactions isolate the phases one at a time. A command-plus-read transaction checks the command byte order. A full 256-bit write checks the buffer layout on the transmit side, and a full 256-bit read checks it on the receive side. An LSB-first mix of all three phases shows that the bit-order switch acts on every phase and not only on data. The all-zero start, the largest divisor and a transaction disturbed by register writes and a second start probe the edges of the sequencing. Seeded random transactions with random counts, divisors, bit order and buffer contents are then compared against a bench model of the expected serial bit stream, busy length and buffer readback, so that a mistake in the offset between phases or in a byte lane shows up as a mismatch in one of these three observations.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

  // width of the clock divider field in the configuration register
  localparam int SPIM_DIV_W = 12;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_TX   = 2'd2,
    PH_RX   = 2'd3
  } spim_phase_e;

  // serial clock period in system cycles: field plus two
  function automatic logic [SPIM_DIV_W:0] spim_divisor(input logic [SPIM_DIV_W-1:0] field);
    return {1'b0, field} + (SPIM_DIV_W+1)'(2);
  endfunction

  // cycles the serial clock stays low in each bit (the larger half)
  function automatic logic [SPIM_DIV_W:0] spim_low_len(input logic [SPIM_DIV_W:0] period);
    return period - (period >> 1);
  endfunction

  // bit position inside a byte for the n-th bit on the wire
  function automatic logic [2:0] spim_bitpos(input logic [2:0] wire_bit, input logic lsb_first);
    return lsb_first ? wire_bit : (3'd7 - wire_bit);
  endfunction

endpackage

// File: rtl/spim_baud.sv
`timescale 1ns/1ps
module spim_baud
  import spim_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [SPIM_DIV_W-1:0] div_field,
  output logic                  sclk,
  output logic                  tick_rise,
  output logic                  tick_end
);

  localparam int CNT_W = SPIM_DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] low_len;

  assign period  = spim_divisor(div_field);
  assign low_len = spim_low_len(period);

  // the clock edge on which the serial clock goes high
  assign tick_rise = run && (cnt == low_len - 1'b1);
  // the clock edge on which the bit ends (serial clock falls)
  assign tick_end  = run && (cnt == period - 1'b1);
  assign sclk      = run && (cnt >= low_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spim_seq.sv
`timescale 1ns/1ps
module spim_seq
  import spim_pkg::*;
#(
  parameter int CW = 6,
  parameter int DW = 9,
  parameter int IW = 8,
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [CW-1:0] cmd_bits,
  input  logic [DW-1:0] tx_bits,
  input  logic [DW-1:0] rx_bits,
  input  logic          tick_end,
  output logic          start_acc,
  output logic          busy,
  output logic          run,
  output spim_phase_e   phase,
  output logic [IW-1:0] phase_idx
);

  logic [TW-1:0] total;
  logic [TW-1:0] gidx;
  logic [TW-1:0] cmd_end_q;
  logic [TW-1:0] tx_end_q;
  logic [TW-1:0] tot_q;
  logic          busy_q;
  logic          run_q;
  logic          last_bit;

  assign total     = TW'(cmd_bits) + TW'(tx_bits) + TW'(rx_bits);
  assign start_acc = start_req && !busy_q;
  assign last_bit  = run_q && tick_end && (gidx == tot_q - 1'b1);
  assign busy      = busy_q;
  assign run       = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      run_q     <= 1'b0;
      gidx      <= '0;
      cmd_end_q <= '0;
      tx_end_q  <= '0;
      tot_q     <= '0;
    end else if (start_acc) begin
      busy_q    <= 1'b1;
      run_q     <= (total != '0);
      gidx      <= '0;
      cmd_end_q <= TW'(cmd_bits);
      tx_end_q  <= TW'(cmd_bits) + TW'(tx_bits);
      tot_q     <= total;
    end else if (last_bit) begin
      run_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (run_q && tick_end) begin
      gidx <= gidx + 1'b1;
    end else if (busy_q && !run_q) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    phase     = PH_IDLE;
    phase_idx = '0;
    if (run_q) begin
      if (gidx < cmd_end_q) begin
        phase     = PH_CMD;
        phase_idx = IW'(gidx);
      end else if (gidx < tx_end_q) begin
        phase     = PH_TX;
        phase_idx = IW'(gidx - cmd_end_q);
      end else begin
        phase     = PH_RX;
        phase_idx = IW'(gidx - tx_end_q);
      end
    end
  end

endmodule

// File: rtl/spim_flash_master.sv
`timescale 1ns/1ps
module spim_flash_master
  import spim_pkg::*;
#(
  parameter int CMD_BYTES  = 4,
  parameter int DATA_BYTES = 32,
  parameter int NUM_CS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  localparam int WORDS     = DATA_BYTES / 4;
  localparam int CMD_MAX   = CMD_BYTES * 8;
  localparam int DATA_MAX  = DATA_BYTES * 8;
  localparam int CW        = $clog2(CMD_MAX + 1);
  localparam int DW        = $clog2(DATA_MAX + 1);
  localparam int IW        = $clog2(DATA_MAX);
  localparam int TW        = $clog2(CMD_MAX + 2 * DATA_MAX + 1);
  localparam int BIW       = $clog2(DATA_BYTES);
  localparam int CIW       = $clog2(CMD_BYTES);
  localparam int DATA_BASE = 8;

  localparam logic [7:0] A_CTL = 8'h00;
  localparam logic [7:0] A_CMD = 8'h04;
  localparam logic [7:0] A_CFG = 8'h28;
  localparam logic [7:0] A_CNT = 8'h2C;
  localparam logic [7:0] A_SEL = 8'h38;

  // register state
  logic [31:0]           cmd_word;
  logic [7:0]            data_b [DATA_BYTES];
  logic [SPIM_DIV_W-1:0] div_q;
  logic                  lsb_q;
  logic                  cpol_q;
  logic                  cpha_q;
  logic [5:0]            cmd_raw;
  logic [8:0]            tx_raw;
  logic [8:0]            rx_raw;
  logic [NUM_CS-1:0]     sel_q;

  // internal events, named for the checker
  logic                  busy;
  logic                  run;
  logic                  start_req;
  logic                  start_acc;
  logic                  start_empty;
  logic                  wr_ok;
  logic                  tick_rise;
  logic                  tick_end;
  logic                  rx_we;
  spim_phase_e           phase;
  logic [IW-1:0]         phase_idx;
  logic [2:0]            bitsel;
  logic [CW-1:0]         cmd_bits;
  logic [DW-1:0]         tx_bits;
  logic [DW-1:0]         rx_bits;

  function automatic logic [CW-1:0] clamp_cmd(input logic [5:0] raw);
    if (int'(raw) > CMD_MAX) return CW'(CMD_MAX);
    return CW'(raw);
  endfunction

  function automatic logic [DW-1:0] clamp_len(input logic [8:0] raw);
    if (int'(raw) > DATA_MAX) return DW'(DATA_MAX);
    return DW'(raw);
  endfunction

  assign cmd_bits    = clamp_cmd(cmd_raw);
  assign tx_bits     = clamp_len(tx_raw);
  assign rx_bits     = clamp_len(rx_raw);
  assign start_req   = reg_wr && (reg_addr == A_CTL) && reg_wdata[8];
  assign start_empty = start_acc && (cmd_bits == '0) && (tx_bits == '0) && (rx_bits == '0);
  assign wr_ok       = reg_wr && !busy;
  assign bitsel      = spim_bitpos(phase_idx[2:0], lsb_q);
  assign rx_we       = (phase == PH_RX) && tick_rise;
  assign spi_cs_n    = ~sel_q;

  spim_seq #(
    .CW(CW), .DW(DW), .IW(IW), .TW(TW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cmd_bits  (cmd_bits),
    .tx_bits   (tx_bits),
    .rx_bits   (rx_bits),
    .tick_end  (tick_end),
    .start_acc (start_acc),
    .busy      (busy),
    .run       (run),
    .phase     (phase),
    .phase_idx (phase_idx)
  );

  spim_baud u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .div_field (div_q),
    .sclk      (spi_sclk),
    .tick_rise (tick_rise),
    .tick_end  (tick_end)
  );

  // byte lanes of the command word, first-out lane first
  logic [7:0]  cmd_lane  [CMD_BYTES];
  logic [31:0] data_word [WORDS];

  for (genvar c = 0; c < CMD_BYTES; c++) begin : g_cmd_lane
    assign cmd_lane[c] = cmd_word[8*(CMD_BYTES-1-c) +: 8];
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_data_word
    assign data_word[w] = {data_b[4*w+3], data_b[4*w+2], data_b[4*w+1], data_b[4*w]};
  end

  always_comb begin
    case (phase)
      PH_CMD:  spi_mosi = cmd_lane[phase_idx[CIW+2:3]][bitsel];
      PH_TX:   spi_mosi = data_b[phase_idx[BIW+2:3]][bitsel];
      default: spi_mosi = 1'b0;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word <= '0;
      div_q    <= '0;
      lsb_q    <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      cmd_raw  <= '0;
      tx_raw   <= '0;
      rx_raw   <= '0;
      sel_q    <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          A_CMD: cmd_word <= reg_wdata;
          A_CFG: begin
            div_q  <= reg_wdata[16 +: SPIM_DIV_W];
            cpha_q <= reg_wdata[5];
            cpol_q <= reg_wdata[4];
            lsb_q  <= reg_wdata[3];
          end
          A_CNT: begin
            cmd_raw <= reg_wdata[29:24];
            rx_raw  <= reg_wdata[20:12];
            tx_raw  <= reg_wdata[8:0];
          end
          default: ;
        endcase
      end
      if (reg_wr && (reg_addr == A_SEL)) begin
        sel_q <= reg_wdata[NUM_CS-1:0];
      end
    end
  end

  // shared data buffer: software writes when idle, receive phase writes when busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_BYTES; i++) data_b[i] <= '0;
    end else if (rx_we) begin
      data_b[phase_idx[BIW+2:3]][bitsel] <= spi_miso;
    end else if (wr_ok) begin
      for (int w = 0; w < WORDS; w++) begin
        if (reg_addr == 8'(DATA_BASE + 4 * w)) begin
          for (int l = 0; l < 4; l++) data_b[4*w+l] <= reg_wdata[8*l +: 8];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL: reg_rdata[16] = busy;
      A_CMD: reg_rdata = cmd_word;
      A_CFG: begin
        reg_rdata[16 +: SPIM_DIV_W] = div_q;
        reg_rdata[5] = cpha_q;
        reg_rdata[4] = cpol_q;
        reg_rdata[3] = lsb_q;
      end
      A_CNT: begin
        reg_rdata[29:24] = cmd_raw;
        reg_rdata[20:12] = rx_raw;
        reg_rdata[8:0]   = tx_raw;
      end
      A_SEL: reg_rdata[NUM_CS-1:0] = sel_q;
      default: begin
        for (int w = 0; w < WORDS; w++) begin
          if (reg_addr == 8'(DATA_BASE + 4 * w)) reg_rdata = data_word[w];
        end
      end
    endcase
  end

endmodule

// File: rtl/spim_flash_master_chk.sv
`timescale 1ns/1ps
module spim_flash_master_chk
  import spim_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spi_sclk,
  input logic                  spi_mosi,
  input logic                  busy,
  input logic                  start_acc,
  input logic                  start_empty,
  input logic                  tick_rise,
  input logic [SPIM_DIV_W-1:0] div_q,
  input logic [31:0]           cmd_word
);

  // R9
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  // R9
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R3
  rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> !spi_sclk);

  // R3
  rise_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> spi_sclk);

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_acc));

  // R12
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_empty |=> (busy && !spi_sclk) ##1 !busy);

  // R13
  regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div_q) && $stable(cmd_word)));

endmodule

bind spim_flash_master spim_flash_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi),
  .busy        (busy),
  .start_acc   (start_acc),
  .start_empty (start_empty),
  .tick_rise   (tick_rise),
  .div_q       (div_q),
  .cmd_word    (cmd_word)
);

// File: tb/spim_flash_master_tb.sv
`timescale 1ns/1ps
module spim_flash_master_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso;
  logic [1:0]  spi_cs_n;

  always #2.5 clk = ~clk;

  spim_flash_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int errors = 0;

  // slave model
  bit       mon_bits [1024];
  int       rises = 0;
  bit       rx_stream [512];
  int       pre_bits = 0;
  int       rx_n_bits = 0;
  bit [7:0] tb_data [32];
  bit [7:0] rx_bytes [32];
  bit [31:0] tb_cmd;

  always @(posedge spi_sclk) begin
    if (rises < 1024) mon_bits[rises] = spi_mosi;
    rises = rises + 1;
  end

  always_comb begin
    if (rises >= pre_bits && (rises - pre_bits) < rx_n_bits)
      spi_miso = rx_stream[rises - pre_bits];
    else
      spi_miso = 1'b0;
  end

  function automatic int exp_period(int field);
    return field + 2;
  endfunction

  function automatic int exp_pos(int n, bit lsb);
    if (lsb) return n % 8;
    return 7 - (n % 8);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic xfer(int cmd_b, int tx_b, int rx_b, int div, bit lsb, bit disturb, string tag);
    logic [31:0] cfg_val, cnt_val, rv;
    int bcnt, guard, total, exp_busy, mism_c, mism_t, mism_r;
    bit done;
    for (int w = 0; w < 8; w++)
      wr(8'(8 + 4*w), {tb_data[4*w+3], tb_data[4*w+2], tb_data[4*w+1], tb_data[4*w]});
    wr(8'h04, tb_cmd);
    cfg_val = (32'(div) << 16) | (32'(lsb) << 3);
    cnt_val = (32'(cmd_b) << 24) | (32'(rx_b) << 12) | 32'(tx_b);
    wr(8'h28, cfg_val);
    wr(8'h2C, cnt_val);
    for (int j = 0; j < 32; j++) rx_bytes[j] = 8'($urandom);
    for (int k = 0; k < rx_b; k++) rx_stream[k] = rx_bytes[k/8][exp_pos(k, lsb)];
    pre_bits = cmd_b + tx_b;
    rx_n_bits = rx_b;
    rises = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_0100;
    bcnt = 0; guard = 0; done = 0;
    while (!done && guard < 60000) begin
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 8'h00;
      #1;
      if (reg_rdata[16]) begin
        bcnt++;
        if (disturb) begin
          case (bcnt)
            2: begin reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'hDEAD_BEEF; end
            3: begin reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = ~tb_cmd; end
            4: begin reg_wr = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'h0800_8008; end
            5: begin reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h0007_0038; end
            6: begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_0100; end
            default: ;
          endcase
        end
      end else begin
        done = 1;
      end
      guard++;
    end
    reg_wr = 1'b0;
    chk(done, "R2", {tag, " busy never cleared"}, guard, 0);
    total = cmd_b + tx_b + rx_b;
    exp_busy = (total == 0) ? 1 : total * exp_period(div);
    chk(bcnt == exp_busy, disturb ? "R11" : (total == 0 ? "R12" : "R2"),
        {tag, " busy cycles"}, bcnt, exp_busy);
    chk(rises == total, total == 0 ? "R12" : "R3", {tag, " sclk rises"}, rises, total);
    chk(spi_sclk == 1'b0, "R9", {tag, " sclk idle"}, spi_sclk, 0);
    mism_c = 0; mism_t = 0;
    for (int i = 0; i < cmd_b; i++)
      if (mon_bits[i] != tb_cmd[8*(3 - i/8) + exp_pos(i, lsb)]) mism_c++;
    for (int i = 0; i < tx_b; i++)
      if (mon_bits[cmd_b + i] != tb_data[i/8][exp_pos(i, lsb)]) mism_t++;
    chk(mism_c == 0, lsb ? "R7" : "R5", {tag, " command bits wrong"}, mism_c, 0);
    chk(mism_t == 0, lsb ? "R7" : "R6", {tag, " transmit bits wrong"}, mism_t, 0);
    mism_r = 0;
    for (int w = 0; w < 8; w++) begin
      rd(8'(8 + 4*w), rv);
      for (int l = 0; l < 4; l++) begin
        int j = 4*w + l;
        bit [7:0] e = (j < rx_b/8) ? rx_bytes[j] : tb_data[j];
        if (rv[8*l +: 8] != e) mism_r++;
      end
    end
    chk(mism_r == 0, disturb ? "R13" : "R8", {tag, " buffer bytes wrong"}, mism_r, 0);
    if (disturb) begin
      rd(8'h04, rv); chk(rv == tb_cmd, "R13", {tag, " command reg"}, rv, tb_cmd);
      rd(8'h28, rv); chk(rv == cfg_val, "R13", {tag, " config reg"}, rv, cfg_val);
      rd(8'h2C, rv); chk(rv == cnt_val, "R4", {tag, " count reg"}, rv, cnt_val);
    end
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, rv); chk(rv == 0, "R1", "control after reset", rv, 0);
    chk(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    chk(spi_cs_n == 2'b11, "R1", "selects after reset", spi_cs_n, 2'b11);
    rd(8'h28, rv); chk(rv == 0, "R1", "config after reset", rv, 0);
    rd(8'h2C, rv); chk(rv == 0, "R1", "counts after reset", rv, 0);
    rd(8'h04, rv); chk(rv == 0, "R1", "command after reset", rv, 0);
    rd(8'h14, rv); chk(rv == 0, "R1", "data word after reset", rv, 0);

    // R10 select lines
    wr(8'h38, 32'h1); chk(spi_cs_n == 2'b10, "R10", "select 0", spi_cs_n, 2'b10);
    wr(8'h38, 32'h2); chk(spi_cs_n == 2'b01, "R10", "select 1", spi_cs_n, 2'b01);
    wr(8'h38, 32'h3); chk(spi_cs_n == 2'b00, "R10", "both selects", spi_cs_n, 2'b00);
    wr(8'h38, 32'h0); chk(spi_cs_n == 2'b11, "R10", "no select", spi_cs_n, 2'b11);
    wr(8'h38, 32'h1);

    // directed corner cases
    for (int j = 0; j < 32; j++) tb_data[j] = 8'($urandom);
    tb_cmd = 32'h0B12_3456;
    xfer(32, 0, 64, 0, 1'b0, 1'b0, "R5 cmd+read");
    xfer(0, 0, 0, 3, 1'b0, 1'b0, "R12 empty");
    for (int j = 0; j < 32; j++) tb_data[j] = 8'($urandom);
    tb_cmd = 32'h0200_0000;
    xfer(8, 256, 0, 1, 1'b0, 1'b0, "R6 full write");
    for (int j = 0; j < 32; j++) tb_data[j] = 8'($urandom);
    xfer(0, 0, 256, 2, 1'b0, 1'b0, "R8 full read");
    for (int j = 0; j < 32; j++) tb_data[j] = 8'($urandom);
    tb_cmd = 32'hA5C3_0F81;
    xfer(16, 24, 16, 3, 1'b1, 1'b0, "R7 lsb first");
    for (int j = 0; j < 32; j++) tb_data[j] = 8'($urandom);
    tb_cmd = 32'h9F00_1122;
    xfer(32, 16, 8, 4, 1'b0, 1'b1, "R11 R13 disturbed");
    tb_cmd = 32'h0600_0000;
    xfer(8, 0, 0, 4095, 1'b0, 1'b0, "R3 max divisor");
    chk(spi_cs_n == 2'b10, "R10", "select held across transactions", spi_cs_n, 2'b10);

    // seeded random transactions
    for (int n = 0; n < 10; n++) begin
      for (int j = 0; j < 32; j++) tb_data[j] = 8'($urandom);
      tb_cmd = $urandom;
      xfer(8 * $urandom_range(0, 4), 8 * $urandom_range(0, 32), 8 * $urandom_range(0, 32),
           $urandom_range(0, 6), 1'($urandom_range(0, 1)), 1'b0, "R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule